// File: doc/BRIEF.md
# DMA Bus Handover Controller

This block sits on the processor side of a shared 16-bit address / 8-bit data bus. It lends that bus to an external DMA master and takes it back. When the master raises its request, the controller lets any processor bus cycle already under way run to its end. It then issues a grant and a hold acknowledge, and turns off all of its own address, data and control drivers through one output enable. Once the master confirms the grant with a rising acknowledge, the controller watches every DMA write on the bus. It compares the write address with an eight-entry tag store, and on a hit it either drops the entry or refreshes its data byte.

The master hands the bus back with a release strobe. The controller answers with a one-clock release acknowledge. It then leaves one clock in which nobody drives the bus, and only after that re-enables its drivers. A small stub stands in for the processor's bus cycle engine. It runs fixed-length read cycles at consecutive addresses, so a return of the bus shows up as the address sequence carrying on from where it paused.

Top module: `dma_handover_ctrl`

## Requirements
- R1: After reset the state machine is in its idle state with one-hot encoding, grant_o, hlda_o and rel_ack_o are low, bus_oe_o is high, and every tag entry is invalid, so look_hit_o is 0.
- R2: With no processor cycle in progress, a request sampled at clock edge k gives grant_o = hlda_o = 1 and bus_oe_o = 0 after edge k+1, and not before.
- R3: A processor cycle (rd_o high for CYC_LEN clocks, default 3) that is running when the request arrives always completes in full, and rd_o is low whenever hlda_o rises.
- R4: While hlda_o is high, bus_oe_o is 0 and no processor cycle starts (rd_o stays 0).
- R5: Snooping begins only on a rising edge of dma_gack_i seen while granted. If the acknowledge is already high before the grant, DMA writes are not snooped (snoop_hit_o = 0) and no entry changes.
- R6: With policy_i = 0 latched, a snooped DMA write (dma_wr_i = 1) whose address equals a valid tag clears that entry's valid bit.
- R7: With policy_i = 1 latched, a snooped write hit replaces the entry's data byte with dma_data_i and keeps it valid.
- R8: policy_i is captured on the clock edge that issues the grant. Changing it during the tenure has no effect on how hits are handled.
- R9: Snooped writes that miss leave all entries unchanged, and snoop_hit_o is 1 exactly for a snooped write that hits.
- R10: A release sampled in snoop mode gives rel_ack_o = 1 for exactly one clock, with hlda_o still 1 and grant_o 0. After that clock hlda_o falls.
- R11: In the clock after hlda_o falls, bus_oe_o stays 0. It returns to 1 one clock later, and processor cycles resume at the next address in sequence.
- R12: If dma_req_i drops before the grant acknowledge rises, the controller returns to idle without snooping, with the same one-clock dead period on the bus.
- R13: Tag fills (fill_i) are ignored while hlda_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_req_i | input | 1 | DMA master asks for the bus |
| dma_gack_i | input | 1 | Master's acknowledge of the grant |
| dma_rel_i | input | 1 | Master gives the bus back |
| dma_wr_i | input | 1 | DMA write on the bus this clock |
| dma_addr_i | input | 16 | DMA bus address |
| dma_data_i | input | 8 | DMA write data |
| policy_i | input | 1 | Snoop hit policy: 0 invalidate, 1 update |
| grant_o | output | 1 | Bus grant to the master |
| hlda_o | output | 1 | Hold acknowledge, bus relinquished |
| rel_ack_o | output | 1 | One-clock acknowledge of release |
| snoop_hit_o | output | 1 | Snooped write hit a valid tag |
| cyc_req_i | input | 1 | Stub: processor wants bus cycles |
| addr_o | output | 16 | Processor bus address |
| rd_o | output | 1 | Processor read cycle active |
| bus_oe_o | output | 1 | Processor address/data/control drivers enabled |
| fill_i | input | 1 | Write a tag entry |
| fill_idx_i | input | 3 | Entry index for fill |
| fill_addr_i | input | 16 | Tag address for fill |
| fill_data_i | input | 8 | Data byte for fill |
| look_addr_i | input | 16 | Lookup address |
| look_hit_o | output | 1 | Lookup found a valid entry |
| look_data_o | output | 8 | Data byte of the matching entry |

## Verification
The snoop path is swept over both policies and every entry index. In each pass all eight entries are refilled, one miss write and one hit write are issued, and the policy input is flipped after the grant. The pass then checks that only the targeted entry changed, and in the way the latched policy dictates. The handover timing is tried with the processor stub idle, which pins the exact two-edge grant latency. It is also tried with continuous processor traffic, where requests land at every phase of a cycle; this shows that grants wait for cycle completion and that addresses resume in order. Separate cases hold the acknowledge high before the grant and drop the request without acknowledge. These set the edge-triggered snoop entry apart from a level-triggered one, and exercise the abort path and its dead clock.

// File: rtl/dma_ho_pkg.sv
package dma_ho_pkg;
  typedef enum logic [4:0] {
    ST_IDLE   = 5'b00001,
    ST_FINISH = 5'b00010,
    ST_GRANT  = 5'b00100,
    ST_SNOOP  = 5'b01000,
    ST_RELACK = 5'b10000
  } ho_state_e;
endpackage

// File: rtl/dma_ho_cycle_stub.sv
module dma_ho_cycle_stub #(
  parameter int AW      = 16,
  parameter int CYC_LEN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_req_i,
  input  logic          may_start_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o
);
  localparam int CW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(CYC_LEN - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cyc_req_i && may_start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;

  AST_NO_START_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !may_start_i) |=> !busy_q); // R4
endmodule

// File: rtl/dma_ho_fsm.sv
module dma_ho_fsm
  import dma_ho_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic gack_i,
  input  logic rel_i,
  input  logic busy_i,
  input  logic policy_i,
  output logic grant_o,
  output logic hlda_o,
  output logic rel_ack_o,
  output logic snoop_en_o,
  output logic pol_o,
  output logic bus_oe_o,
  output logic may_start_o
);
  ho_state_e state_q, state_d;
  logic gack_q, dead_q, pol_q;
  logic gack_rise, held;

  assign gack_rise = gack_i && !gack_q;
  assign held      = (state_q == ST_GRANT) || (state_q == ST_SNOOP) || (state_q == ST_RELACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_FINISH;
      ST_FINISH: if (!req_i) state_d = ST_IDLE;
                 else if (!busy_i) state_d = ST_GRANT;
      ST_GRANT:  if (!req_i) state_d = ST_IDLE;
                 else if (gack_rise) state_d = ST_SNOOP;
      ST_SNOOP:  if (rel_i) state_d = ST_RELACK;
      ST_RELACK: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gack_q  <= 1'b0;
      dead_q  <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gack_q  <= gack_i;
      // one idle clock on the bus after any tenure
      dead_q  <= held && (state_d == ST_IDLE);
      if (state_q == ST_FINISH && state_d == ST_GRANT) pol_q <= policy_i;
    end
  end

  assign grant_o     = (state_q == ST_GRANT) || (state_q == ST_SNOOP);
  assign hlda_o      = held;
  assign rel_ack_o   = (state_q == ST_RELACK);
  assign snoop_en_o  = (state_q == ST_SNOOP);
  assign pol_o       = pol_q;
  assign bus_oe_o    = ((state_q == ST_IDLE) || (state_q == ST_FINISH)) && !dead_q;
  assign may_start_o = (state_q == ST_IDLE) && !dead_q;

  AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q)); // R1
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !bus_oe_o); // R4
  AST_DEAD_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) |-> !bus_oe_o); // R11
  AST_RELACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_ack_o |=> (!rel_ack_o && !hlda_o)); // R10
  AST_POLICY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && $past(hlda_o)) |-> $stable(pol_q)); // R8
endmodule

// File: rtl/dma_ho_snoop_tags.sv
module dma_ho_snoop_tags #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snoop_en_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pol_i,
  input  logic          fill_en_i,
  input  logic [IW-1:0] fill_idx_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          hit_o,
  output logic          look_hit_o,
  output logic [DW-1:0] look_data_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      tag_q  [ENTRIES];
  logic [DW-1:0]      data_q [ENTRIES];
  logic               snoop_wr;

  assign snoop_wr = snoop_en_i && wr_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign match[g] = valid_q[g] && (tag_q[g] == addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (fill_en_i && (fill_idx_i == IW'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_addr_i;
        data_q[g]  <= fill_data_i;
      end else if (snoop_wr && match[g]) begin
        if (pol_i) data_q[g] <= data_i;
        else       valid_q[g] <= 1'b0;
      end
    end
  end

  assign hit_o = snoop_wr && (|match);

  always_comb begin
    look_hit_o  = 1'b0;
    look_data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!look_hit_o && valid_q[i] && (tag_q[i] == look_addr_i)) begin
        look_hit_o  = 1'b1;
        look_data_o = data_q[i];
      end
    end
  end

  AST_MISS_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_wr && !hit_o && !fill_en_i) |=> $stable(valid_q)); // R9
  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pol_i && !fill_en_i) |=> ($countones(valid_q) < $countones($past(valid_q)))); // R6
  AST_UPDATE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_wr && pol_i && !fill_en_i) |=> $stable(valid_q)); // R7
endmodule

// File: rtl/dma_handover_ctrl.sv
module dma_handover_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ENTRIES = 8,
  parameter int CYC_LEN = 3,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_req_i,
  input  logic          dma_gack_i,
  input  logic          dma_rel_i,
  input  logic          dma_wr_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic [DW-1:0] dma_data_i,
  input  logic          policy_i,
  output logic          grant_o,
  output logic          hlda_o,
  output logic          rel_ack_o,
  output logic          snoop_hit_o,
  input  logic          cyc_req_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          bus_oe_o,
  input  logic          fill_i,
  input  logic [IW-1:0] fill_idx_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          look_hit_o,
  output logic [DW-1:0] look_data_o
);
  logic busy, snoop_en, pol, may_start;

  dma_ho_cycle_stub #(.AW(AW), .CYC_LEN(CYC_LEN)) u_stub (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_req_i(cyc_req_i),
    .may_start_i(may_start), .busy_o(busy), .addr_o(addr_o)
  );

  dma_ho_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(dma_req_i), .gack_i(dma_gack_i),
    .rel_i(dma_rel_i), .busy_i(busy), .policy_i(policy_i), .grant_o(grant_o),
    .hlda_o(hlda_o), .rel_ack_o(rel_ack_o), .snoop_en_o(snoop_en), .pol_o(pol),
    .bus_oe_o(bus_oe_o), .may_start_o(may_start)
  );

  dma_ho_snoop_tags #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .snoop_en_i(snoop_en), .wr_i(dma_wr_i),
    .addr_i(dma_addr_i), .data_i(dma_data_i), .pol_i(pol),
    .fill_en_i(fill_i && !hlda_o), .fill_idx_i(fill_idx_i),
    .fill_addr_i(fill_addr_i), .fill_data_i(fill_data_i),
    .look_addr_i(look_addr_i), .hit_o(snoop_hit_o),
    .look_hit_o(look_hit_o), .look_data_o(look_data_o)
  );

  assign rd_o = busy;

  AST_GRANT_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> !busy); // R3
  AST_NO_CYCLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !rd_o); // R4
  AST_SNOOP_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(snoop_en) |-> $past(dma_gack_i)); // R5
endmodule

// File: tb/sim_dma_handover_ctrl.sv
module sim_dma_handover_ctrl;
  localparam int AW = 16, DW = 8, ENTRIES = 8, CYC_LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_req = 0, dma_gack = 0, dma_rel = 0, dma_wr = 0, policy = 0;
  logic [AW-1:0] dma_addr = '0, fill_addr = '0, look_addr = '0;
  logic [DW-1:0] dma_data = '0, fill_data = '0;
  logic cyc_req = 0, fill = 0;
  logic [2:0] fill_idx = '0;
  logic grant, hlda, rel_ack, snoop_hit, rd, bus_oe, look_hit;
  logic [AW-1:0] addr;
  logic [DW-1:0] look_data;

  int n_cmp = 0, n_err = 0, m_cmp = 0, m_err = 0;
  logic [AW-1:0] exp_addr = '0;
  logic prev_rd = 0;
  int rd_len = 0;

  always #2.5 clk = ~clk;

  dma_handover_ctrl #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES), .CYC_LEN(CYC_LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dma_req_i(dma_req), .dma_gack_i(dma_gack),
    .dma_rel_i(dma_rel), .dma_wr_i(dma_wr), .dma_addr_i(dma_addr),
    .dma_data_i(dma_data), .policy_i(policy), .grant_o(grant), .hlda_o(hlda),
    .rel_ack_o(rel_ack), .snoop_hit_o(snoop_hit), .cyc_req_i(cyc_req),
    .addr_o(addr), .rd_o(rd), .bus_oe_o(bus_oe), .fill_i(fill),
    .fill_idx_i(fill_idx), .fill_addr_i(fill_addr), .fill_data_i(fill_data),
    .look_addr_i(look_addr), .look_hit_o(look_hit), .look_data_o(look_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] tag_of(input int e, input int p);
    return AW'(16'h4000 + e * 37 + p * 3);
  endfunction

  // monitor: full-length cycles, sequential addresses, no cycles while held
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd && !prev_rd) begin
        m_cmp++;
        if (addr !== exp_addr) begin
          m_err++;
          $display("FAIL R11: cycle address actual %0h expected %0h", addr, exp_addr);
        end
        exp_addr = exp_addr + 1'b1;
        rd_len = 0;
      end
      if (rd) rd_len++;
      if (!rd && prev_rd) begin
        m_cmp++;
        if (rd_len != CYC_LEN) begin
          m_err++;
          $display("FAIL R3: cycle length actual %0d expected %0d", rd_len, CYC_LEN);
        end
      end
      if (hlda && rd) begin
        m_err++;
        $display("FAIL R4: rd_o actual 1 expected 0 while held");
      end
      prev_rd = rd;
    end
  end

  task automatic fill_all(input int p);
    for (int e = 0; e < ENTRIES; e++) begin
      fill = 1; fill_idx = 3'(e); fill_addr = tag_of(e, p); fill_data = DW'(8'h10 + e);
      step(1);
    end
    fill = 0;
  endtask

  task automatic wait_hlda(input string rq);
    int k = 0;
    while (!hlda && k < 20) begin step(1); k++; end
    chk(rq, 32'(k <= CYC_LEN + 2), 1);
    chk(rq, {rd, bus_oe, grant}, 3'b001);
  endtask

  task automatic release_bus();
    dma_rel = 1; step(1);
    chk("R10", {rel_ack, hlda, grant}, 3'b110);
    dma_rel = 0; dma_req = 0; dma_gack = 0; step(1);
    chk("R10", {rel_ack, hlda}, 2'b00);
    chk("R11", bus_oe, 0);
    step(1);
    chk("R11", bus_oe, 1);
  endtask

  initial begin
    step(2);
    look_addr = '0;
    #1;
    chk("R1", {grant, hlda, rel_ack, bus_oe, look_hit}, 5'b00010);
    rst_n = 1;
    step(1);
    chk("R1", {grant, hlda, rel_ack, bus_oe, look_hit}, 5'b00010);

    // exact grant latency with idle stub
    fill_all(0);
    dma_req = 1; step(1);
    chk("R2", {hlda, grant}, 2'b00);
    step(1);
    chk("R2", {hlda, grant, bus_oe}, 3'b110);
    dma_gack = 1; step(1);
    release_bus();

    // sweep: every policy x entry, with processor traffic
    cyc_req = 1;
    for (int p = 0; p < 2; p++) begin
      for (int idx = 0; idx < ENTRIES; idx++) begin
        fill_all(p);
        step(idx % (CYC_LEN + 1));
        policy = p[0];
        dma_req = 1;
        wait_hlda("R3");
        chk("R4", bus_oe, 0);
        policy = ~p[0]; // R8: late change must not matter
        dma_gack = 1; step(1);
        dma_wr = 1; dma_addr = 16'hFFFF; dma_data = 8'hEE;
        #1; chk("R9", snoop_hit, 0);
        step(1);
        dma_addr = tag_of(idx, p); dma_data = DW'(8'hC0 ^ idx);
        #1; chk("R9", snoop_hit, 1);
        step(1);
        dma_wr = 0;
        fill = 1; fill_idx = 3'(idx); fill_addr = 16'h0123; fill_data = 8'h55;
        step(1);
        fill = 0;
        look_addr = 16'h0123; #1;
        chk("R13", look_hit, 0);
        release_bus();
        policy = 0;
        for (int e = 0; e < ENTRIES; e++) begin
          look_addr = tag_of(e, p); #1;
          if (e != idx) begin
            chk("R9", {look_hit, look_data}, {1'b1, DW'(8'h10 + e)});
          end else if (p == 0) begin
            chk("R6", look_hit, 0);
          end else begin
            chk("R7", {look_hit, look_data}, {1'b1, DW'(8'hC0 ^ idx)});
          end
        end
        look_addr = 16'h0123; #1;
        chk("R13", look_hit, 0);
      end
    end

    // acknowledge already high: no snoop, then request dropped
    fill_all(0);
    dma_gack = 1; step(1);
    policy = 0; dma_req = 1;
    wait_hlda("R5");
    step(2);
    dma_wr = 1; dma_addr = tag_of(0, 0); dma_data = 8'h99;
    #1; chk("R5", snoop_hit, 0);
    step(1);
    dma_wr = 0; dma_req = 0; step(1);
    chk("R12", {hlda, grant, bus_oe}, 3'b000);
    step(1);
    chk("R12", bus_oe, 1);
    dma_gack = 0;
    look_addr = tag_of(0, 0); #1;
    chk("R5", {look_hit, look_data}, {1'b1, 8'h10});

    // request dropped before acknowledge, acknowledge never raised
    dma_req = 1;
    wait_hlda("R12");
    dma_req = 0; step(1);
    chk("R12", {hlda, bus_oe}, 2'b00);
    step(1);
    chk("R12", bus_oe, 1);

    cyc_req = 0;
    step(CYC_LEN + 4);
    chk("R11", 32'(exp_addr > 0), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_err + m_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp + 1, n_err + m_err + 1);
    $finish;
  end
endmodule